// File: doc/BRIEF.md
# Dispatch Stall and Skid Buffer Controller

This block sits between a register-rename stage and an issue queue and runs one controller per hardware thread. Each cycle a thread may present a bundle of up to `IN_W` renamed micro-ops. The controller moves them, oldest first, into the issue queue, at most `WIDTH` per cycle. A load needs a free load-queue slot and a store needs a free store-queue slot. A five-state machine (Idle, Running, Blocked, Unblocking, Squashing) decides each cycle whether the controller dispatches, parks the bundle, drains parked work or discards everything.

When it cannot take work, the controller raises a one-cycle block request to the rename stage. Micro-ops that are still in flight from rename land in a per-thread skid buffer. The buffer holds `(DELAY+1)*IN_W` entries, so the upstream stage can keep sending for `DELAY` cycles after it sees the block request. Once the stall clears, the controller drains the buffer before it accepts live input again. When the buffer is empty it raises a one-cycle unblock pulse.

Every cycle the controller reports to rename how many entries it removed. The count covers entries that were dispatched, dropped because they were marked squashed, or flushed. Separate counts give the loads and the stores among them, so rename can return its free-slot credits. All status and count outputs are combinational from the current state and the current inputs. They are valid in the same cycle.

Top module: `disp_skid_ctrl`

## Requirements
- R1: After reset every thread is in state Idle (code 0) with an empty skid buffer. States are encoded Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.
- R2: Live input slots are valid as a prefix from slot 0. Dispatched entries appear in order on `disp_vld_o` from slot 0 upward, at most `WIDTH` per cycle. Each dispatched entry keeps its kind and tag.
- R3: In Idle, a cycle that dispatches at least one entry moves the thread to Running. A cycle that dispatches nothing leaves it in Idle.
- R4: A stall is present when `rob_sq_i` is high or `iq_free_i` is zero. A stall dispatches nothing, parks the live bundle in the skid buffer and moves the thread to Blocked. `block_o` pulses only if the thread was not already Blocked or Unblocking.
- R5: When no stall or squash is present, Blocked moves to Unblocking and Squashing moves to Running. While Unblocking, the controller dispatches from the head of the skid buffer, and live input is appended behind the parked entries.
- R6: A thread that is Unblocking (or was Blocked and is now released) and whose skid buffer becomes empty pulses `unblock_o` and returns to Running.
- R7: `squash_i` moves the thread to Squashing and discards both the skid buffer and the live bundle. It pulses `unblock_o` if the thread was Blocked or Unblocking.
- R8: If entries of the current source remain after `WIDTH` have been handled, the thread moves to Blocked and `unblock_o` stays low. Any undispatched live entries go to the skid buffer.
- R9: An entry of kind load (2'b01) needs an unused load slot from `lq_free_i`, and an entry of kind store (2'b10) needs an unused store slot from `sq_free_i`. Every dispatched entry uses one slot of `iq_free_i`. When a needed slot is missing, dispatch stops at that entry and the thread blocks as in R8.
- R10: An entry with its squashed flag set is removed without being dispatched and uses no queue slot.
- R11: `cnt_all_o` counts every entry removed this cycle, whether dispatched, dropped or flushed. `cnt_ld_o` and `cnt_st_o` count the loads and the stores among them.
- R12: The skid buffer holds `(DELAY+1)*IN_W` entries. It never overflows if rename stops sending `DELAY` cycles after a block pulse, so every entry sent is eventually credited.
- R13: `block_o` and `unblock_o` are never high in the same cycle for one thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | THREADS*IN_W | Live bundle slot valid (prefix) |
| in_kind_i | input | THREADS*IN_W*2 | Slot kind: 00 other, 01 load, 10 store |
| in_sqd_i | input | THREADS*IN_W | Slot marked squashed |
| in_tag_i | input | THREADS*IN_W*TAG_W | Slot payload tag |
| squash_i | input | THREADS | Squash from commit |
| rob_sq_i | input | THREADS | Reorder buffer still squashing (stall) |
| iq_free_i | input | THREADS*FREE_W | Free issue-queue slots |
| lq_free_i | input | THREADS*FREE_W | Free load-queue slots |
| sq_free_i | input | THREADS*FREE_W | Free store-queue slots |
| disp_vld_o | output | THREADS*WIDTH | Dispatch slot valid |
| disp_kind_o | output | THREADS*WIDTH*2 | Dispatched entry kind |
| disp_tag_o | output | THREADS*WIDTH*TAG_W | Dispatched entry tag |
| block_o | output | THREADS | Block request pulse to rename |
| unblock_o | output | THREADS | Unblock pulse to rename |
| cnt_all_o | output | THREADS*CNT_W | Entries removed this cycle |
| cnt_ld_o | output | THREADS*CNT_W | Loads among removed entries |
| cnt_st_o | output | THREADS*CNT_W | Stores among removed entries |
| state_o | output | THREADS*3 | Current state per thread |

## Verification
The first stimulus pattern keeps every queue open and sends bundles of random size. Its bundles are often wider than the dispatch width, which separates dispatch that is limited by width from dispatch that is limited by resources. A second pattern starves the issue, load and store queues and raises reorder-buffer stalls. It exercises the path that parks entries and then drains them in Unblocking, and it shows whether parked entries come out ahead of live ones. A third pattern is dense with squashed entries and commit squashes. It separates dropping, which still returns credit, from flushing, and shows whether `unblock_o` follows the state the thread had before. A final quiet drain confirms that the total credited matches the total sent, so no entry is lost or duplicated in the skid buffer.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4
  } disp_state_e;

  localparam logic [1:0] KIND_LD = 2'b01;
  localparam logic [1:0] KIND_ST = 2'b10;
endpackage

// File: rtl/dsc_skid.sv
module dsc_skid #(
  parameter int CAP    = 6,
  parameter int PUSH_W = 3,
  parameter int E_W    = 7,
  parameter int CNT_W  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic [CNT_W-1:0]             pop_i,
  input  logic [CNT_W-1:0]             push_n_i,
  input  logic [PUSH_W-1:0][E_W-1:0]   push_i,
  output logic [CAP-1:0][E_W-1:0]      q_o,
  output logic [CNT_W-1:0]             cnt_o
);
  logic [CAP-1:0][E_W-1:0] q_d;
  logic [CNT_W-1:0]        cnt_d, rem;

  always_comb begin
    rem = cnt_o - pop_i;
    q_d = '0;
    for (int s = 0; s < CAP; s++)
      if (CNT_W'(s) >= pop_i && CNT_W'(s) < cnt_o) q_d[s - int'(pop_i)] = q_o[s];
    for (int k = 0; k < PUSH_W; k++)
      if (CNT_W'(k) < push_n_i && int'(rem) + k < CAP) q_d[int'(rem) + k] = push_i[k];
    cnt_d = rem + push_n_i;
    if (flush_i) begin
      q_d   = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      cnt_o <= '0;
    end else begin
      q_o   <= q_d;
      cnt_o <= cnt_d;
    end
  end

  AST_SKID_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> (int'(rem) + int'(push_n_i) <= CAP && pop_i <= cnt_o)); // R12
endmodule

// File: rtl/dsc_lane.sv
module dsc_lane
  import dsc_pkg::*;
#(
  parameter int WIDTH  = 2,
  parameter int IN_W   = 3,
  parameter int DELAY  = 1,
  parameter int TAG_W  = 4,
  parameter int FREE_W = 3,
  localparam int CAP   = (DELAY + 1) * IN_W,
  localparam int E_W   = TAG_W + 3,
  localparam int CNT_W = $clog2(CAP + IN_W + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [IN_W-1:0]               in_vld_i,
  input  logic [IN_W-1:0][1:0]          in_kind_i,
  input  logic [IN_W-1:0]               in_sqd_i,
  input  logic [IN_W-1:0][TAG_W-1:0]    in_tag_i,
  input  logic                          squash_i,
  input  logic                          rob_sq_i,
  input  logic [FREE_W-1:0]             iq_free_i,
  input  logic [FREE_W-1:0]             lq_free_i,
  input  logic [FREE_W-1:0]             sq_free_i,
  output logic [WIDTH-1:0]              disp_vld_o,
  output logic [WIDTH-1:0][1:0]         disp_kind_o,
  output logic [WIDTH-1:0][TAG_W-1:0]   disp_tag_o,
  output logic                          block_o,
  output logic                          unblock_o,
  output logic [CNT_W-1:0]              cnt_all_o,
  output logic [CNT_W-1:0]              cnt_ld_o,
  output logic [CNT_W-1:0]              cnt_st_o,
  output logic [2:0]                    state_o
);
  disp_state_e state_q, state_d, eff;
  logic [IN_W-1:0][E_W-1:0] live, push_vec;
  logic [CAP-1:0][E_W-1:0]  skid_q;
  logic [CNT_W-1:0]         skid_n, live_n, pop, push_n;
  logic                     flush, push_en, use_skid, stop, hit;
  logic [E_W-1:0]           e;
  int                       n, taken, nd, iq_u, lq_u, sq_u, pf;

  function automatic void credit(input logic [1:0] k, inout logic [CNT_W-1:0] a,
                                 inout logic [CNT_W-1:0] l, inout logic [CNT_W-1:0] s);
    a = a + 1'b1;
    if (k == KIND_LD) l = l + 1'b1;
    if (k == KIND_ST) s = s + 1'b1;
  endfunction

  always_comb begin
    live_n = '0;
    for (int i = 0; i < IN_W; i++) begin
      live[i] = {in_tag_i[i], in_sqd_i[i], in_kind_i[i]};
      if (in_vld_i[i]) live_n = live_n + 1'b1;
    end
  end

  always_comb begin
    state_d = state_q; eff = state_q;
    block_o = 1'b0; unblock_o = 1'b0;
    cnt_all_o = '0; cnt_ld_o = '0; cnt_st_o = '0;
    disp_vld_o = '0; disp_kind_o = '0; disp_tag_o = '0;
    flush = 1'b0; push_en = 1'b0; pf = 0; pop = '0;
    use_skid = 1'b0; stop = 1'b0; hit = 1'b0; e = '0;
    n = 0; taken = 0; nd = 0; iq_u = 0; lq_u = 0; sq_u = 0;
    if (squash_i) begin
      flush = 1'b1;
      for (int j = 0; j < CAP; j++)
        if (CNT_W'(j) < skid_n) credit(skid_q[j][1:0], cnt_all_o, cnt_ld_o, cnt_st_o);
      for (int i = 0; i < IN_W; i++)
        if (in_vld_i[i]) credit(live[i][1:0], cnt_all_o, cnt_ld_o, cnt_st_o);
      unblock_o = (state_q == ST_BLK || state_q == ST_UNB);
      state_d   = ST_SQ;
    end else if (rob_sq_i || iq_free_i == '0) begin
      block_o = !(state_q == ST_BLK || state_q == ST_UNB);
      push_en = 1'b1;
      state_d = ST_BLK;
    end else begin
      if (state_q == ST_BLK) eff = ST_UNB;
      if (state_q == ST_SQ)  eff = ST_RUN;
      if (eff == ST_UNB && skid_n == '0) begin
        unblock_o = 1'b1;
        eff       = ST_RUN;
      end
      use_skid = (eff == ST_UNB);
      n = use_skid ? int'(skid_n) : int'(live_n);
      for (int i = 0; i < WIDTH; i++) begin
        if (!stop && i < n) begin
          e = use_skid ? skid_q[i] : live[i];
          if (e[2]) begin
            credit(e[1:0], cnt_all_o, cnt_ld_o, cnt_st_o);
            taken++;
          end else if (iq_u >= int'(iq_free_i) ||
                       (e[1:0] == KIND_LD && lq_u >= int'(lq_free_i)) ||
                       (e[1:0] == KIND_ST && sq_u >= int'(sq_free_i))) begin
            stop = 1'b1;
          end else begin
            credit(e[1:0], cnt_all_o, cnt_ld_o, cnt_st_o);
            disp_vld_o[nd]  = 1'b1;
            disp_kind_o[nd] = e[1:0];
            disp_tag_o[nd]  = e[E_W-1:3];
            iq_u++;
            if (e[1:0] == KIND_LD) lq_u++;
            if (e[1:0] == KIND_ST) sq_u++;
            nd++;
            taken++;
          end
        end
      end
      hit = stop || (taken < n);
      if (use_skid) begin
        pop     = CNT_W'(taken);
        push_en = 1'b1;
      end else if (hit) begin
        push_en = 1'b1;
        pf      = taken;
      end
      if (hit) begin
        block_o   = (eff != ST_UNB);
        unblock_o = 1'b0;
        state_d   = ST_BLK;
      end else if (use_skid) begin
        if (int'(skid_n) - taken + int'(live_n) == 0) begin
          unblock_o = 1'b1;
          state_d   = ST_RUN;
        end else state_d = ST_UNB;
      end else begin
        state_d = (eff == ST_IDLE && nd == 0) ? ST_IDLE : ST_RUN;
      end
    end
    push_n = push_en ? live_n - CNT_W'(pf) : '0;
    for (int k = 0; k < IN_W; k++)
      push_vec[k] = (k + pf < IN_W) ? live[k + pf] : '0;
  end

  dsc_skid #(.CAP(CAP), .PUSH_W(IN_W), .E_W(E_W), .CNT_W(CNT_W)) u_skid (
    .clk_i, .rst_ni, .flush_i(flush), .pop_i(pop), .push_n_i(push_n),
    .push_i(push_vec), .q_o(skid_q), .cnt_o(skid_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
  assign state_o = state_q;

  AST_BLK_UNBLK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(block_o && unblock_o)); // R13
  AST_BLOCK_TO_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |=> state_q == ST_BLK); // R4
  AST_STALL_NO_DISP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rob_sq_i && !squash_i) |-> disp_vld_o == '0); // R4
  AST_SQUASH_TO_SQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> state_q == ST_SQ); // R7
  AST_UNBLOCK_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unblock_o |=> (state_q == ST_RUN || state_q == ST_SQ)); // R6
  AST_IQ_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(disp_vld_o) <= int'(iq_free_i)); // R9
  AST_CREDIT_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_ld_o) + int'(cnt_st_o) <= int'(cnt_all_o)); // R11
  AST_SKID_CLEAR_AFTER_SQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> skid_n == '0); // R7
endmodule

// File: rtl/disp_skid_ctrl.sv
module disp_skid_ctrl #(
  parameter int THREADS = 2,
  parameter int WIDTH   = 2,
  parameter int IN_W    = 3,
  parameter int DELAY   = 1,
  parameter int TAG_W   = 4,
  parameter int FREE_W  = 3,
  localparam int CAP    = (DELAY + 1) * IN_W,
  localparam int CNT_W  = $clog2(CAP + IN_W + 1)
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic [THREADS-1:0][IN_W-1:0]              in_vld_i,
  input  logic [THREADS-1:0][IN_W-1:0][1:0]         in_kind_i,
  input  logic [THREADS-1:0][IN_W-1:0]              in_sqd_i,
  input  logic [THREADS-1:0][IN_W-1:0][TAG_W-1:0]   in_tag_i,
  input  logic [THREADS-1:0]                        squash_i,
  input  logic [THREADS-1:0]                        rob_sq_i,
  input  logic [THREADS-1:0][FREE_W-1:0]            iq_free_i,
  input  logic [THREADS-1:0][FREE_W-1:0]            lq_free_i,
  input  logic [THREADS-1:0][FREE_W-1:0]            sq_free_i,
  output logic [THREADS-1:0][WIDTH-1:0]             disp_vld_o,
  output logic [THREADS-1:0][WIDTH-1:0][1:0]        disp_kind_o,
  output logic [THREADS-1:0][WIDTH-1:0][TAG_W-1:0]  disp_tag_o,
  output logic [THREADS-1:0]                        block_o,
  output logic [THREADS-1:0]                        unblock_o,
  output logic [THREADS-1:0][CNT_W-1:0]             cnt_all_o,
  output logic [THREADS-1:0][CNT_W-1:0]             cnt_ld_o,
  output logic [THREADS-1:0][CNT_W-1:0]             cnt_st_o,
  output logic [THREADS-1:0][2:0]                   state_o
);
  for (genvar t = 0; t < THREADS; t++) begin : g_lane
    dsc_lane #(
      .WIDTH(WIDTH), .IN_W(IN_W), .DELAY(DELAY), .TAG_W(TAG_W), .FREE_W(FREE_W)
    ) u_lane (
      .clk_i, .rst_ni,
      .in_vld_i(in_vld_i[t]), .in_kind_i(in_kind_i[t]), .in_sqd_i(in_sqd_i[t]),
      .in_tag_i(in_tag_i[t]), .squash_i(squash_i[t]), .rob_sq_i(rob_sq_i[t]),
      .iq_free_i(iq_free_i[t]), .lq_free_i(lq_free_i[t]), .sq_free_i(sq_free_i[t]),
      .disp_vld_o(disp_vld_o[t]), .disp_kind_o(disp_kind_o[t]), .disp_tag_o(disp_tag_o[t]),
      .block_o(block_o[t]), .unblock_o(unblock_o[t]),
      .cnt_all_o(cnt_all_o[t]), .cnt_ld_o(cnt_ld_o[t]), .cnt_st_o(cnt_st_o[t]),
      .state_o(state_o[t])
    );
  end
endmodule

// File: tb/disp_skid_ctrl_bench.sv
module disp_skid_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int T = 2, W = 2, IW = 3, DLY = 1, TW = 4, FW = 3;
  localparam int CAP = (DLY + 1) * IW;
  localparam int CW = $clog2(CAP + IW + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [T-1:0][IW-1:0]         in_vld, in_sqd;
  logic [T-1:0][IW-1:0][1:0]    in_kind;
  logic [T-1:0][IW-1:0][TW-1:0] in_tag;
  logic [T-1:0]                 squash, rob;
  logic [T-1:0][FW-1:0]         iqf, lqf, sqf;
  logic [T-1:0][W-1:0]          dvld;
  logic [T-1:0][W-1:0][1:0]     dkind;
  logic [T-1:0][W-1:0][TW-1:0]  dtag;
  logic [T-1:0]                 blk, unb;
  logic [T-1:0][CW-1:0]         call, cld, cst;
  logic [T-1:0][2:0]            st;

  disp_skid_ctrl u_disp_skid_ctrl (
    .clk_i, .rst_ni, .in_vld_i(in_vld), .in_kind_i(in_kind), .in_sqd_i(in_sqd),
    .in_tag_i(in_tag), .squash_i(squash), .rob_sq_i(rob), .iq_free_i(iqf),
    .lq_free_i(lqf), .sq_free_i(sqf), .disp_vld_o(dvld), .disp_kind_o(dkind),
    .disp_tag_o(dtag), .block_o(blk), .unblock_o(unb), .cnt_all_o(call),
    .cnt_ld_o(cld), .cnt_st_o(cst), .state_o(st)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  int total = 0, bad = 0;
  int ms [T];
  int sk [T][$];
  int ub [T], win [T];
  int sent [T], credited [T];
  bit done = 0;

  task automatic chk(bit ok, string req, string ph, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (phase %s) %s act=%0d exp=%0d", req, ph, what, act, exp);
    end
  endtask

  task automatic model(int t, string ph);
    int lv[$]; int dq[$];
    int eb, eu, cd, cl, cs, ns, eff, taken, n, iu, lu, su, e, k;
    bit fromsk, stop, hit;
    eb = 0; eu = 0; cd = 0; cl = 0; cs = 0; ns = ms[t];
    for (int i = 0; i < IW; i++)
      if (in_vld[t][i]) lv.push_back(int'(in_kind[t][i]) | (int'(in_sqd[t][i]) << 2) | (int'(in_tag[t][i]) << 3));
    if (squash[t]) begin
      foreach (sk[t][j]) begin cd++; if ((sk[t][j] & 3) == 1) cl++; if ((sk[t][j] & 3) == 2) cs++; end
      foreach (lv[j]) begin cd++; if ((lv[j] & 3) == 1) cl++; if ((lv[j] & 3) == 2) cs++; end
      sk[t].delete();
      eu = (ms[t] == 2 || ms[t] == 3);
      ns = 4;
    end else if (rob[t] || iqf[t] == 0) begin
      eb = !(ms[t] == 2 || ms[t] == 3);
      foreach (lv[j]) sk[t].push_back(lv[j]);
      ns = 2;
    end else begin
      eff = ms[t];
      if (ms[t] == 2) eff = 3;
      if (ms[t] == 4) eff = 1;
      if (eff == 3 && sk[t].size() == 0) begin eu = 1; eff = 1; end
      fromsk = (eff == 3);
      n = fromsk ? sk[t].size() : lv.size();
      taken = 0; stop = 0; iu = 0; lu = 0; su = 0;
      while (!stop && taken < W && taken < n) begin
        e = fromsk ? sk[t][taken] : lv[taken];
        k = e & 3;
        if ((e >> 2) & 1) begin
          cd++; if (k == 1) cl++; if (k == 2) cs++; taken++;
        end else if (iu >= int'(iqf[t]) || (k == 1 && lu >= int'(lqf[t])) ||
                     (k == 2 && su >= int'(sqf[t]))) begin
          stop = 1;
        end else begin
          cd++; if (k == 1) begin cl++; lu++; end if (k == 2) begin cs++; su++; end
          iu++; dq.push_back(e); taken++;
        end
      end
      hit = stop || taken < n;
      if (fromsk) begin
        for (int j = 0; j < taken; j++) void'(sk[t].pop_front());
        foreach (lv[j]) sk[t].push_back(lv[j]);
      end else if (hit) begin
        for (int j = taken; j < lv.size(); j++) sk[t].push_back(lv[j]);
      end
      if (hit) begin eb = (eff != 3); eu = 0; ns = 2; end
      else if (fromsk) begin
        if (sk[t].size() == 0) begin eu = 1; ns = 1; end else ns = 3;
      end else ns = (eff == 0 && dq.size() == 0) ? 0 : 1;
    end
    chk(int'(st[t]) == ms[t], "R5", ph, "state", int'(st[t]), ms[t]);
    chk(blk[t] == eb[0], "R4", ph, "block", int'(blk[t]), eb);
    chk(unb[t] == eu[0], "R6", ph, "unblock", int'(unb[t]), eu);
    chk(!(blk[t] && unb[t]), "R13", ph, "block&unblock", int'(blk[t] & unb[t]), 0);
    chk(int'(call[t]) == cd, "R11", ph, "cnt_all", int'(call[t]), cd);
    chk(int'(cld[t]) == cl && int'(cst[t]) == cs, "R11", ph, "cnt_ld/st",
        int'(cld[t]) * 100 + int'(cst[t]), cl * 100 + cs);
    for (int s = 0; s < W; s++) begin
      chk(dvld[t][s] == (s < dq.size()), "R2", ph, "disp_vld", int'(dvld[t][s]), int'(s < dq.size()));
      if (s < dq.size() && dvld[t][s])
        chk({dtag[t][s], dkind[t][s]} == (TW+2)'(((dq[s] >> 3) << 2) | (dq[s] & 3)), "R2", ph,
            "disp_entry", int'({dtag[t][s], dkind[t][s]}), ((dq[s] >> 3) << 2) | (dq[s] & 3));
    end
    credited[t] += int'(call[t]);
    ms[t] = ns;
  endtask

  task automatic run_phase(string ph, int cyc, int p_in, int p_sq, int p_sqh, int p_rob,
                           int iq_lo, int iq_hi, int ls_lo, int ls_hi);
    int nb;
    for (int c = 0; c < cyc; c++) begin
      for (int t = 0; t < T; t++) begin
        in_vld[t] = '0; in_kind[t] = '0; in_sqd[t] = '0; in_tag[t] = '0;
        if ((ub[t] == 0 || win[t] > 0) && $urandom_range(99, 0) < p_in) begin
          nb = $urandom_range(IW, 1);
          for (int i = 0; i < nb; i++) begin
            in_vld[t][i]  = 1'b1;
            in_kind[t][i] = 2'($urandom_range(2, 0));
            in_sqd[t][i]  = ($urandom_range(99, 0) < p_sq);
            in_tag[t][i]  = TW'($urandom);
          end
          sent[t] += nb;
        end
        if (ub[t] != 0 && win[t] > 0) win[t]--;
        squash[t] = ($urandom_range(99, 0) < p_sqh);
        rob[t]    = ($urandom_range(99, 0) < p_rob);
        iqf[t]    = FW'($urandom_range(iq_hi, iq_lo));
        lqf[t]    = FW'($urandom_range(ls_hi, ls_lo));
        sqf[t]    = FW'($urandom_range(ls_hi, ls_lo));
      end
      #1;
      for (int t = 0; t < T; t++) begin
        model(t, ph);
        if (blk[t]) begin ub[t] = 1; win[t] = DLY; end
        if (unb[t]) ub[t] = 0;
      end
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    in_vld = '0; in_kind = '0; in_sqd = '0; in_tag = '0;
    squash = '0; rob = '0; iqf = '1; lqf = '1; sqf = '1;
    for (int t = 0; t < T; t++) begin ms[t] = 0; ub[t] = 0; win[t] = 0; sent[t] = 0; credited[t] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int t = 0; t < T; t++) begin
      chk(st[t] == 3'd0, "R1", "reset", "state", int'(st[t]), 0);
      chk(dvld[t] == '0 && !blk[t] && !unb[t], "R1", "reset", "outputs",
          int'(dvld[t]) + int'(blk[t]) + int'(unb[t]), 0);
    end
    run_phase("R3", 3, 0, 0, 0, 0, 7, 7, 7, 7);    // R3: idle stays idle without dispatch
    run_phase("R3", 4, 100, 0, 0, 0, 7, 7, 7, 7);  // R3: first dispatch leaves idle
    run_phase("R2", 30, 70, 0, 0, 0, 7, 7, 7, 7);
    run_phase("R8", 40, 100, 0, 0, 0, 7, 7, 7, 7); // bundles wider than WIDTH
    run_phase("R4", 50, 80, 0, 0, 15, 0, 3, 2, 7);
    run_phase("R9", 50, 90, 0, 0, 0, 1, 7, 0, 1);
    run_phase("R10", 40, 90, 50, 0, 0, 1, 7, 0, 3);
    run_phase("R7", 60, 90, 10, 15, 10, 0, 4, 0, 3);
    run_phase("R5", 120, 80, 15, 5, 10, 0, 7, 0, 7);
    run_phase("R6", 30, 0, 0, 0, 0, 7, 7, 7, 7);   // quiet drain
    for (int t = 0; t < T; t++)
      chk(credited[t] == sent[t], "R12", "drain", "credited vs sent", credited[t], sent[t]);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule